// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block moves an 18-bit word between two ports, A and B, over two independent paths: A toward B and B toward A. Each path keeps one storage bit per data bit and runs it in one of three ways. With its latch-open control high the path is transparent and the destination shows the source at once. With the latch-open control low the path holds its stored word, and a rising edge of the path's strobe loads a new word unless the path's active-low capture enable is high. An active-low drive enable per path gates the destination outputs.

The A side is three-state: it presents a data word and one enable bit. The B side is open-drain: each line has a pull-low request, asserted only when the path is enabled and the bit to send is 0. A released line is pulled to 1 by the surrounding bus, so several devices can share a B line as a wired-OR. The strobes are slow control inputs synchronous to the block clock `clk`. A small state machine per path, with states `STB_LOW` and `STB_HIGH`, tracks the strobe level. The transition `STB_LOW` to `STB_HIGH` is the rising edge that loads the bank. The transition `STB_HIGH` to `STB_LOW` follows a falling strobe. In every other case the state stays as it is. Reset puts the machine in `STB_HIGH`, so a strobe that is already high when reset ends loads nothing. The active-low asynchronous reset `rst_n` clears both storage banks to zero.

Top module: `dual_path_bus_xcvr`

## Requirements
- R1: While reset is low and after it is released, both storage banks hold zero. With a path's latch-open control low and its drive enable low, `a_out` reads 0 and every `b_pull_low` bit reads 1.
- R2: When `ab_oe_n` is 1, every `b_pull_low` bit is 0. When `ba_oe_n` is 1, `a_out_en` is 0. This holds whatever the other inputs are.
- R3: With the latch-open control high and the drive enable low, the destination follows the source in the same cycle, before any clock edge.
- R4: With the latch-open control low and the capture enable low, a strobe that is sampled low at one `clk` edge and high at the next loads the source word at that second edge. The destination shows the word from then on.
- R5: With the capture enable high, a rising strobe leaves the stored word unchanged.
- R6: With the latch-open control low and no rising strobe, a change of the source word has no effect on the destination.
- R7: While the latch-open control is high, the bank loads the source at every `clk` edge. After the control falls, including when it falls while the strobe is high, the destination holds the word present at the last edge before the fall.
- R8: `b_pull_low[i]` is 1 exactly when `ab_oe_n` is 0 and the A-to-B value bit i is 0. The B-to-A path reads the resolved wire, so a low driven by another device on that line reaches `a_out`.
- R9: The A-to-B controls and data have no effect on the B-to-A stored word.
- R10: When reset ends with the strobe already high, nothing is loaded until the strobe has been sampled low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples strobes and updates the banks |
| rst_n | input | 1 | Asynchronous active-low reset; clears both banks |
| a_in | input | 18 | A-side data toward B |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ab_ce_n | input | 1 | A-to-B capture enable, active low |
| ab_le | input | 1 | A-to-B latch-open control, high = transparent |
| ab_strobe | input | 1 | A-to-B capture strobe, loads on its rising edge |
| b_pull_low | output | 18 | Per-line pull-low request on the open-drain B side |
| b_in | input | 18 | Resolved B-side wire value toward A |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_ce_n | input | 1 | B-to-A capture enable, active low |
| ba_le | input | 1 | B-to-A latch-open control, high = transparent |
| ba_strobe | input | 1 | B-to-A capture strobe, loads on its rising edge |
| a_out | output | 18 | A-side data from B |
| a_out_en | output | 1 | A-side three-state enable, high = driving |

## Verification
Assertions check on every cycle that the bank loads the source while the latch-open control is high or on an enabled rising strobe, and that it holds otherwise. They also check that the edge detector never reports two rising edges in a row and that the open-drain outputs release whenever the path is disabled. Only the bench scenarios can show the ordering cases. These include the latch-open control falling while the strobe is high, a strobe that is high when reset ends, the wired-OR effect of another device's low reaching the A side, and the two directions leaving each other's stored words alone.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int unsigned XCVR_WIDTH = 18;

    typedef enum logic {
        STB_LOW  = 1'b0,
        STB_HIGH = 1'b1
    } stb_state_e;
endpackage

// File: rtl/strobe_edge_fsm.sv
module strobe_edge_fsm
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    stb_state_e state_q;
    stb_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STB_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        unique case (state_q)
            STB_LOW: begin
                if (strobe) begin
                    state_d = STB_HIGH;
                    rise    = 1'b1;
                end
            end
            STB_HIGH: begin
                if (!strobe) begin
                    state_d = STB_LOW;
                end
            end
            default: state_d = STB_HIGH;
        endcase
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise) else $error("double rise"); // R4
endmodule

// File: rtl/hold_bank.sv
module hold_bank #(
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             le,
    input  logic             ce_n,
    input  logic             rise,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] store_q;
    logic             load;

    assign load = le || (rise && !ce_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (load) begin
            store_q <= din;
        end
    end

    assign dout = le ? din : store_q;

    AST_LOAD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> (store_q == $past(din))) else $error("open load"); // R7
    AST_CAPTURE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !ce_n && rise) |=> (store_q == $past(din))) else $error("capture"); // R4
    AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && ce_n) |=> $stable(store_q)) else $error("inhibit"); // R5
    AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !rise) |=> $stable(store_q)) else $error("hold"); // R6
endmodule

// File: rtl/path_unit.sv
module path_unit #(
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src,
    input  logic             le,
    input  logic             ce_n,
    input  logic             strobe,
    output logic [WIDTH-1:0] value
);
    logic rise;

    strobe_edge_fsm u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .rise   (rise)
    );

    hold_bank #(.WIDTH(WIDTH)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (src),
        .le    (le),
        .ce_n  (ce_n),
        .rise  (rise),
        .dout  (value)
    );
endmodule

// File: rtl/dual_path_bus_xcvr.sv
module dual_path_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic             ab_oe_n,
    input  logic             ab_ce_n,
    input  logic             ab_le,
    input  logic             ab_strobe,
    output logic [WIDTH-1:0] b_pull_low,
    input  logic [WIDTH-1:0] b_in,
    input  logic             ba_oe_n,
    input  logic             ba_ce_n,
    input  logic             ba_le,
    input  logic             ba_strobe,
    output logic [WIDTH-1:0] a_out,
    output logic             a_out_en
);
    logic [WIDTH-1:0] ab_val;
    logic [WIDTH-1:0] ba_val;

    path_unit #(.WIDTH(WIDTH)) u_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (a_in),
        .le     (ab_le),
        .ce_n   (ab_ce_n),
        .strobe (ab_strobe),
        .value  (ab_val)
    );

    path_unit #(.WIDTH(WIDTH)) u_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (b_in),
        .le     (ba_le),
        .ce_n   (ba_ce_n),
        .strobe (ba_strobe),
        .value  (ba_val)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_open_drain
        assign b_pull_low[i] = !ab_oe_n && !ab_val[i];
    end

    assign a_out    = ba_val;
    assign a_out_en = !ba_oe_n;

    AST_B_RELEASED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ab_oe_n |-> (b_pull_low == '0)) else $error("b not released"); // R2
    AST_B_FOLLOWS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_oe_n && ab_le) |-> (b_pull_low == ~a_in)) else $error("b open"); // R3
    AST_A_FOLLOWS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |-> (a_out == b_in)) else $error("a open"); // R3
endmodule

// File: tb/test_dual_path_bus_xcvr.sv
module test_dual_path_bus_xcvr;
    localparam int W = 18;
    localparam int NV = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic ab_oe_n = 1'b0, ab_ce_n = 1'b0, ab_le = 1'b0, ab_strobe = 1'b0;
    logic [W-1:0] b_pull_low;
    logic [W-1:0] ext_pull = '0;
    logic [W-1:0] b_wire;
    logic ba_oe_n = 1'b0, ba_ce_n = 1'b0, ba_le = 1'b0, ba_strobe = 1'b0;
    logic [W-1:0] a_out;
    logic a_out_en;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    assign b_wire = ~(b_pull_low | ext_pull);

    dual_path_bus_xcvr i_dual_path_bus_xcvr (
        .clk(clk), .rst_n(rst_n), .a_in(a_in),
        .ab_oe_n(ab_oe_n), .ab_ce_n(ab_ce_n), .ab_le(ab_le), .ab_strobe(ab_strobe),
        .b_pull_low(b_pull_low), .b_in(b_wire),
        .ba_oe_n(ba_oe_n), .ba_ce_n(ba_ce_n), .ba_le(ba_le), .ba_strobe(ba_strobe),
        .a_out(a_out), .a_out_en(a_out_en)
    );

    // row: {oe_n, le, ce_n, strobe, a_in, expected b_pull_low}
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h00000}, // R2 disabled
        {1'b0, 1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h3FFFF}, // R6 holds reset zero
        {1'b0, 1'b0, 1'b0, 1'b1, 18'h15555, 18'h2AAAA}, // R4 capture
        {1'b0, 1'b0, 1'b0, 1'b1, 18'h0F0F0, 18'h2AAAA}, // R6 strobe steady high
        {1'b0, 1'b0, 1'b0, 1'b0, 18'h0F0F0, 18'h2AAAA}, // R6 strobe falls
        {1'b0, 1'b0, 1'b1, 1'b1, 18'h0F0F0, 18'h2AAAA}, // R5 inhibited edge
        {1'b0, 1'b0, 1'b1, 1'b0, 18'h0F0F0, 18'h2AAAA}, // R5 held
        {1'b0, 1'b1, 1'b1, 1'b0, 18'h3C3C3, 18'h03C3C}, // R3 transparent
        {1'b0, 1'b1, 1'b1, 1'b1, 18'h12345, 18'h2DCBA}, // R3 transparent, strobe high
        {1'b0, 1'b0, 1'b1, 1'b1, 18'h00001, 18'h2DCBA}, // R7 latch falls with strobe high
        {1'b0, 1'b0, 1'b0, 1'b1, 18'h00001, 18'h2DCBA}, // R7 still held
        {1'b0, 1'b0, 1'b0, 1'b0, 18'h00001, 18'h2DCBA}, // R6 held
        {1'b0, 1'b0, 1'b0, 1'b1, 18'h00001, 18'h3FFFE}, // R4 capture after low
        {1'b1, 1'b0, 1'b0, 1'b1, 18'h00001, 18'h00000}  // R2 disabled again
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 a_out in reset", a_out, '0);
        chk("R1 b_pull_low in reset", b_pull_low, '1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 a_out after reset", a_out, '0);
        chk("R1 b_pull_low after reset", b_pull_low, '1);
        chk("R1 a_out_en", {17'b0, a_out_en}, 18'h1);

        // A-to-B table walk
        for (int i = 0; i < NV; i++) begin
            {ab_oe_n, ab_le, ab_ce_n, ab_strobe, a_in} = VEC[i][39:18];
            @(negedge clk);
            chk($sformatf("R2-R7 row %0d", i), b_pull_low, VEC[i][17:0]);
        end

        // R9: B-to-A stored word untouched by the A-to-B activity
        chk("R9 a_out unchanged", a_out, '0);

        // B-to-A mirrored path (ab side disabled so the wire is set by ext_pull)
        ab_oe_n = 1'b1;
        ba_le = 1'b1;
        ext_pull = ~18'h2468A;
        #1;
        chk("R3 b-to-a transparent same cycle", a_out, 18'h2468A);
        @(negedge clk);
        ba_le = 1'b0;
        ext_pull = ~18'h11111;
        @(negedge clk);
        chk("R7 b-to-a holds after latch falls", a_out, 18'h2468A);
        ba_strobe = 1'b1;
        @(negedge clk);
        chk("R4 b-to-a capture", a_out, 18'h11111);
        ba_ce_n = 1'b1;
        ba_strobe = 1'b0;
        ext_pull = '0;
        @(negedge clk);
        ba_strobe = 1'b1;
        @(negedge clk);
        chk("R5 b-to-a inhibited", a_out, 18'h11111);
        ba_oe_n = 1'b1;
        #1;
        chk("R2 a_out_en off", {17'b0, a_out_en}, '0);

        // R8: open-drain and wired-OR
        ba_oe_n = 1'b0;
        ba_le = 1'b1;
        ab_oe_n = 1'b0;
        ab_le = 1'b1;
        a_in = 18'h3FFFF;
        ext_pull = 18'h00008;
        #1;
        chk("R8 high releases lines", b_pull_low, '0);
        chk("R8 other device low reaches a_out", a_out, 18'h3FFF7);
        a_in = 18'h3FFFE;
        #1;
        chk("R8 low pulls line", b_pull_low, 18'h00001);
        chk("R8 wired-OR of two lows", a_out, 18'h3FFF6);
        @(negedge clk);

        // R10: strobe high across reset release
        ab_le = 1'b0;
        ab_ce_n = 1'b0;
        ab_strobe = 1'b1;
        ext_pull = '0;
        a_in = 18'h00155;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 no load from strobe high at reset", b_pull_low, 18'h3FFFF);
        ab_strobe = 1'b0;
        @(negedge clk);
        ab_strobe = 1'b1;
        @(negedge clk);
        chk("R10 load after fresh rising strobe", b_pull_low, 18'h3FEAA);

        finish_run();
    end
endmodule